// File: doc/BRIEF.md
# Dual Gated Timer/Counter Pair

This block holds two independent 16-bit timer/counters behind a small 8-bit register bus. Each unit either counts ticks from a shared clock prescaler, or counts falling edges seen on its own external count pin. The prescaler divides the clock by 12, or by 4 when its fast option is selected. Each unit has a run bit. It also has an optional gate: when the gate is selected, the unit counts only while its gate pin is high.

Each unit runs in one of two modes. The first is a plain 16-bit free-running count. The second is an 8-bit count in the low byte that reloads from the high byte when it wraps. On every wrap the unit raises a one-cycle pulse, which a serial port can use as its bit-rate clock. The wrap also sets a sticky flag that software clears.

Register map (byte addresses on `bus_addr`): 0 unit 0 low byte, 1 unit 0 high byte, 2 unit 1 low byte, 3 unit 1 high byte, 4 mode, 5 control. Addresses 6 and 7 read as zero. Reads are combinational. Writes take effect at the clock edge while `bus_wr` is high.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all count bytes, the mode register and the control register read 0, and ovf_pulse and ovf_flag are 0.
- R2: Writing address 0/1 (unit 0) or 2/3 (unit 1) loads the low/high count byte. Address 4 holds the mode bits and address 5 the control bits. Any address reads back the current state, with unused bits reading 0.
- R3: A shared prescaler, free-running from reset, produces one tick every 12 clocks. When control bit 7 is 1 it produces one tick every 4 clocks. A running unit in timer mode (mode bit 1 of its nibble = 0) advances by one at the clock edge that ends a tick cycle.
- R4: Each count pin is sampled at every rising edge. A fall is recognised in the cycle where the older sample is 1 and the newer is 0. A running unit in pin mode (mode bit 1 of its nibble = 1) advances by one at the next edge.
- R5: When gating is selected (mode bit 2 of the unit's nibble = 1), the unit advances only while its gate pin is 1. When gating is not selected, the gate pin has no effect.
- R6: With its run bit at 0 (control bit 0 for unit 0, bit 1 for unit 1), a unit's count does not change except by bus writes.
- R7: In 16-bit mode (mode bit 0 of the nibble = 0), an advance from 0xFFFF gives 0x0000 and counts as an overflow.
- R8: In reload mode (mode bit 0 = 1), an advance only touches the low byte. From 0xFF the low byte takes the high byte's value, which is an overflow, and the high byte never changes by counting.
- R9: An overflow sets the unit's sticky flag (control bit 2 for unit 0, bit 3 for unit 1). Writing 0 to that bit clears it and writing 1 leaves it unchanged. If an overflow and a clearing write meet in one cycle, the flag ends set.
- R10: In a cycle where either count byte of a unit is written, that unit neither advances nor overflows; the written byte takes the bus value.
- R11: ovf_pulse[i] is 1 for exactly the one cycle after the edge at which unit i overflowed, and it is also the cycle in which ovf_flag[i] first reads 1.
- R12: The two units are independent: the pins, bits and writes of one unit never change the other unit's count, flag or pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | Gate pins, one per unit |
| ovf_pulse | output | 2 | One-cycle overflow pulse per unit, usable as bit-rate clock |
| ovf_flag | output | 2 | Sticky overflow flag per unit |

## Verification
Two pairs of actions can land on the same edge. A count byte write can meet an advance, and a flag-clearing control write can meet an overflow. The bench sets these up directly. It writes the low byte every cycle while the count sits at 0xFFFF, and it times a clearing write to the edge at which a pin-mode unit wraps. It then expects the write to win in the first case and the set to win in the second. A cycle-accurate reference model in the bench covers the same collisions during a long random run, and every register and output is compared after each edge.

// File: rtl/tmr_pair_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the timer/counter pair.
// Assumes exactly two units; register layout below depends on that.
package tmr_pair_pkg;
    localparam int UNITS      = 2;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 2 * BYTE_W;
    localparam int REG_COUNT  = 2 * UNITS + 2;
    localparam int ADDR_W     = $clog2(REG_COUNT + 2);
    localparam int DIV_SLOW   = 12;
    localparam int DIV_FAST   = 4;
    // register addresses
    localparam int ADR_MODE   = 2 * UNITS;
    localparam int ADR_CTRL   = 2 * UNITS + 1;
    // mode register: one nibble per unit
    localparam int MODE_NIB   = 4;
    localparam int MB_RELOAD  = 0;
    localparam int MB_PIN     = 1;
    localparam int MB_GATE    = 2;
    // control register fields
    localparam int CB_RUN     = 0;
    localparam int CB_FLAG    = CB_RUN + UNITS;
    localparam int CB_FAST    = BYTE_W - 1;

    typedef struct packed {
        logic gate_on;
        logic use_pin;
        logic reload;
    } unit_mode_t;
endpackage

// File: rtl/tick_divider.sv
`timescale 1ns/1ps
// Module: tick_divider
// Free-running prescaler shared by both units. Raises tick for one
// cycle out of DIV_SLOW, or out of DIV_FAST when fast is high.
// Assumes DIV_FAST >= 2 and DIV_SLOW >= 2. A change of fast takes
// effect on the running phase; a phase beyond the new limit ticks at once.
module tick_divider #(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic tick
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int PW      = $clog2(DIV_MAX);
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;

    // select the terminal phase for the current rate
    always_comb begin
        limit = fast ? LIM_FAST : LIM_SLOW;
        tick  = (phase_q >= limit);
    end

    // advance the phase, wrapping after the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                   // R3
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LIM_SLOW || phase_q <= LIM_FAST);       // R3
endmodule

// File: rtl/pin_fall_detect.sv
`timescale 1ns/1ps
// Module: pin_fall_detect
// Samples one count pin every clock and reports a high-to-low change
// between the two most recent samples. Assumes the pin is already
// synchronous to clk (no metastability stage here).
module pin_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic smp_new_q;
    logic smp_old_q;

    // two-deep sample history of the pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_new_q <= 1'b0;
            smp_old_q <= 1'b0;
        end else begin
            smp_new_q <= pin;
            smp_old_q <= smp_new_q;
        end
    end

    // a fall is an old sample of 1 followed by a new sample of 0
    always_comb fall = smp_old_q & ~smp_new_q;

    AST_FALL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);                                   // R4
endmodule

// File: rtl/count_unit.sv
`timescale 1ns/1ps
// Module: count_unit
// One 16-bit timer/counter: picks its advance source (tick or pin
// fall), applies run and gate, counts in 16-bit or low-byte reload
// form, and produces a registered overflow pulse and sticky flag.
// Assumes byte writes arrive as one-cycle strobes and win over counting.
module count_unit
    import tmr_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  unit_mode_t        mode,
    input  logic              run,
    input  logic              gate_pin,
    input  logic              tick,
    input  logic              fall,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf_pulse,
    output logic              ovf_flag
);
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic              enable;
    logic              step;
    logic              any_wr;
    logic              at_top;
    logic              wrap;

    // qualify and select the advance request, detect the wrap point
    always_comb begin
        enable = run & (mode.gate_on ? gate_pin : 1'b1);
        step   = enable & (mode.use_pin ? fall : tick);
        any_wr = wr_lo | wr_hi;
        at_top = mode.reload ? (&lo_q) : (&{hi_q, lo_q});
        wrap   = step & ~any_wr & at_top;
        cnt    = {hi_q, lo_q};
    end

    // count bytes: bus write first, then reload or 16-bit advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (any_wr) begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
        end else if (step) begin
            if (mode.reload) lo_q <= (&lo_q) ? hi_q : lo_q + 1'b1;
            else             {hi_q, lo_q} <= {hi_q, lo_q} + 1'b1;
        end
    end

    // overflow pulse and sticky flag, set dominating clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_pulse <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            ovf_pulse <= wrap;
            if (wrap)          ovf_flag <= 1'b1;
            else if (flag_clr) ovf_flag <= 1'b0;
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_lo) |-> lo_q == $past(wdata));            // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step) && !$past(any_wr)) |-> cnt == $past(cnt)); // R6
    AST_RELOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode.reload) && !$past(wr_hi)) |-> hi_q == $past(hi_q)); // R8
    AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_flag);                           // R11
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);                         // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag_clr && !wrap) |-> !ovf_flag);           // R9
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
// Module: tmr_pair (top)
// Two gated timer/counters with a shared prescaler and an 8-bit
// register bus. Holds the mode and control registers, decodes bus
// writes into per-unit strobes and muxes reads combinationally.
// Assumes a single-cycle write strobe and synchronous pins.
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int DIV_SLOW_P = DIV_SLOW,
    parameter int DIV_FAST_P = DIV_FAST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [UNITS-1:0]  cnt_pin,
    input  logic [UNITS-1:0]  gate_pin,
    output logic [UNITS-1:0]  ovf_pulse,
    output logic [UNITS-1:0]  ovf_flag
);
    unit_mode_t              mode_q [UNITS];
    logic [UNITS-1:0]        run_q;
    logic                    fast_q;
    logic                    tick;
    logic                    wr_mode;
    logic                    wr_ctrl;
    logic [UNITS-1:0]        fall;
    logic [UNITS-1:0]        wr_lo;
    logic [UNITS-1:0]        wr_hi;
    logic [UNITS-1:0]        flag_clr;
    logic [CNT_W-1:0]        cnt [UNITS];

    // decode shared register writes
    always_comb begin
        wr_mode = bus_wr && (bus_addr == ADDR_W'(ADR_MODE));
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    end

    // control register: run bits and prescaler rate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            fast_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q  <= bus_wdata[CB_RUN +: UNITS];
            fast_q <= bus_wdata[CB_FAST];
        end
    end

    tick_divider #(
        .DIV_SLOW (DIV_SLOW_P),
        .DIV_FAST (DIV_FAST_P)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .fast  (fast_q),
        .tick  (tick)
    );

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        // per-unit byte strobes and flag clear
        always_comb begin
            wr_lo[g]    = bus_wr && (bus_addr == ADDR_W'(2 * g));
            wr_hi[g]    = bus_wr && (bus_addr == ADDR_W'(2 * g + 1));
            flag_clr[g] = wr_ctrl && !bus_wdata[CB_FLAG + g];
        end

        // per-unit mode nibble
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[g] <= '0;
            end else if (wr_mode) begin
                mode_q[g].reload  <= bus_wdata[g * MODE_NIB + MB_RELOAD];
                mode_q[g].use_pin <= bus_wdata[g * MODE_NIB + MB_PIN];
                mode_q[g].gate_on <= bus_wdata[g * MODE_NIB + MB_GATE];
            end
        end

        pin_fall_detect u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cnt_pin[g]),
            .fall  (fall[g])
        );

        count_unit u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode_q[g]),
            .run       (run_q[g]),
            .gate_pin  (gate_pin[g]),
            .tick      (tick),
            .fall      (fall[g]),
            .wr_lo     (wr_lo[g]),
            .wr_hi     (wr_hi[g]),
            .wdata     (bus_wdata),
            .flag_clr  (flag_clr[g]),
            .cnt       (cnt[g]),
            .ovf_pulse (ovf_pulse[g]),
            .ovf_flag  (ovf_flag[g])
        );
    end

    // combinational read mux
    always_comb begin
        bus_rdata = '0;
        for (int u = 0; u < UNITS; u++) begin
            if (bus_addr == ADDR_W'(2 * u))     bus_rdata = cnt[u][BYTE_W-1:0];
            if (bus_addr == ADDR_W'(2 * u + 1)) bus_rdata = cnt[u][CNT_W-1:BYTE_W];
            if (bus_addr == ADDR_W'(ADR_MODE)) begin
                bus_rdata[u * MODE_NIB + MB_RELOAD] = mode_q[u].reload;
                bus_rdata[u * MODE_NIB + MB_PIN]    = mode_q[u].use_pin;
                bus_rdata[u * MODE_NIB + MB_GATE]   = mode_q[u].gate_on;
            end
        end
        if (bus_addr == ADDR_W'(ADR_CTRL)) begin
            bus_rdata[CB_RUN +: UNITS]  = run_q;
            bus_rdata[CB_FLAG +: UNITS] = ovf_flag;
            bus_rdata[CB_FAST]          = fast_q;
        end
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ctrl) |-> run_q == $past(bus_wdata[CB_RUN +: UNITS])); // R2
    AST_PULSE_ONEHOT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse[0] && !$past(run_q[0])) |-> 1'b0);      // R6
endmodule

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic, compared each
// cycle against a reference model built from the requirements.
module sim_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ovf_pulse;
    logic [1:0] ovf_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    int          m_pre;
    logic        m_fast;
    logic [1:0]  m_run, m_new, m_old, m_pulse, m_flag;
    logic [2:0]  m_mode [2];
    logic [15:0] m_cnt [2];

    tmr_pair u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input int a);
        logic [7:0] r = '0;
        case (a)
            0: r = m_cnt[0][7:0];
            1: r = m_cnt[0][15:8];
            2: r = m_cnt[1][7:0];
            3: r = m_cnt[1][15:8];
            4: r = {1'b0, m_mode[1], 1'b0, m_mode[0]};
            5: r = {m_fast, 3'b000, m_flag, m_run};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_reset();
        m_pre = 0; m_fast = 0; m_run = 0; m_new = 0; m_old = 0;
        m_pulse = 0; m_flag = 0;
        for (int i = 0; i < 2; i++) begin m_mode[i] = 0; m_cnt[i] = 0; end
    endtask

    // one clock edge of the reference model, from old state and inputs
    task automatic model_step();
        int lim = m_fast ? 3 : 11;
        logic tick = (m_pre >= lim);
        logic [15:0] nc [2];
        logic [1:0] np, nf;
        for (int i = 0; i < 2; i++) begin
            logic fl = m_old[i] & ~m_new[i];
            logic en = m_run[i] & (m_mode[i][2] ? gate_pin[i] : 1'b1);
            logic st = en & (m_mode[i][1] ? fl : tick);
            logic wl = bus_wr && bus_addr == 3'(2 * i);
            logic wh = bus_wr && bus_addr == 3'(2 * i + 1);
            logic top = m_mode[i][0] ? (m_cnt[i][7:0] == 8'hFF) : (m_cnt[i] == 16'hFFFF);
            logic wrp = st & ~(wl | wh) & top;
            logic clr = bus_wr && bus_addr == 3'd5 && !bus_wdata[2 + i];
            nc[i] = m_cnt[i];
            if (wl | wh) begin
                if (wl) nc[i][7:0]  = bus_wdata;
                if (wh) nc[i][15:8] = bus_wdata;
            end else if (st) begin
                if (m_mode[i][0]) nc[i][7:0] = top ? m_cnt[i][15:8] : m_cnt[i][7:0] + 8'd1;
                else              nc[i] = m_cnt[i] + 16'd1;
            end
            np[i] = wrp;
            nf[i] = wrp ? 1'b1 : (clr ? 1'b0 : m_flag[i]);
        end
        m_pre = tick ? 0 : m_pre + 1;
        if (bus_wr && bus_addr == 3'd4) begin
            m_mode[0] = bus_wdata[2:0];
            m_mode[1] = bus_wdata[6:4];
        end
        if (bus_wr && bus_addr == 3'd5) begin
            m_run = bus_wdata[1:0];
            m_fast = bus_wdata[7];
        end
        m_cnt[0] = nc[0]; m_cnt[1] = nc[1];
        m_pulse = np; m_flag = nf;
        m_old = m_new; m_new = cnt_pin;
    endtask

    // compare all registers and outputs against the model
    task automatic compare_all(input string tag);
        for (int a = 0; a < 6; a++) begin
            bus_addr = 3'(a);
            #0.1;
            check({tag, " reg"}, 16'(bus_rdata), 16'(model_read(a)));
        end
        check({tag, " pulse"}, 16'(ovf_pulse), 16'(m_pulse));
        check({tag, " flag"}, 16'(ovf_flag), 16'(m_flag));
    endtask

    // advance one clock with the inputs set by the caller
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_wr = 1'b0;
        compare_all(tag);
    endtask

    task automatic wr(input int a, input logic [7:0] d, input string tag);
        bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
        cyc(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    initial begin
        logic [15:0] snap;
        void'($urandom(32'd5150));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a); #0.1;
            check("R1 reset read", 16'(bus_rdata), 16'h0);
        end
        check("R1 reset pulse", 16'(ovf_pulse), 16'h0);
        check("R1 reset flag", 16'(ovf_flag), 16'h0);

        // R2: register loads and read back, R6 stopped units hold
        wr(0, 8'h12, "R2"); wr(1, 8'h34, "R2"); wr(2, 8'h56, "R2"); wr(3, 8'h78, "R2");
        wr(4, 8'h77, "R2"); wr(4, 8'h00, "R2");
        idle(30, "R6 run off");
        bus_addr = 3'd1; #0.1;
        check("R6 held high byte", 16'(bus_rdata), 16'h34);

        // R3: slow then fast timer mode on unit 0
        wr(0, 8'h00, "R3"); wr(1, 8'h00, "R3");
        wr(5, 8'h0D, "R3 slow");
        idle(50, "R3 slow");
        wr(5, 8'h8D, "R3 fast");
        idle(40, "R3 fast");

        // R7 + R11: 16-bit wrap
        wr(1, 8'hFF, "R7"); wr(0, 8'hFE, "R7");
        idle(20, "R7 wrap");
        check("R7 flag set", 16'(ovf_flag[0]), 16'h1);

        // R9: writing 1 keeps the flag, writing 0 clears it
        wr(5, 8'h8D, "R9 keep");
        check("R9 keep flag", 16'(ovf_flag[0]), 16'h1);
        wr(5, 8'h89, "R9 clear");
        check("R9 cleared", 16'(ovf_flag[0]), 16'h0);

        // R10: continuous low writes at 0xFFFF block advance and overflow
        wr(1, 8'hFF, "R10");
        for (int k = 0; k < 16; k++) begin
            wr(0, 8'hFF, "R10 write wins");
            check("R10 no pulse", 16'(ovf_pulse[0]), 16'h0);
        end
        check("R10 no flag", 16'(ovf_flag[0]), 16'h0);

        // R8: reload mode
        wr(1, 8'hF0, "R8"); wr(0, 8'hFD, "R8"); wr(4, 8'h01, "R8");
        idle(60, "R8 reload");
        bus_addr = 3'd1; #0.1;
        check("R8 high byte kept", 16'(bus_rdata), 16'hF0);

        // R4 + R9 collision: pin-mode wrap meets a clearing write
        wr(4, 8'h02, "R4"); wr(1, 8'hFF, "R4"); wr(0, 8'hFF, "R4");
        cnt_pin[0] = 1'b1; idle(3, "R4 high");
        cnt_pin[0] = 1'b0; cyc("R4 fall sampled");
        bus_addr = 3'd5; bus_wdata = 8'h89; bus_wr = 1'b1;
        cyc("R9 set beats clear");
        check("R9 set beats clear", 16'(ovf_flag[0]), 16'h1);
        check("R11 pulse on wrap", 16'(ovf_pulse[0]), 16'h1);
        cyc("R11 pulse drop");
        check("R11 pulse one cycle", 16'(ovf_pulse[0]), 16'h0);

        // R5: gating on unit 1 in timer mode
        wr(4, 8'h42, "R5"); wr(5, 8'h8F, "R5");
        gate_pin = 2'b00;
        bus_addr = 3'd2; #0.1; snap = 16'(bus_rdata);
        idle(24, "R5 gate low");
        bus_addr = 3'd2; #0.1;
        check("R5 gate low holds", 16'(bus_rdata), snap);
        gate_pin = 2'b10;
        idle(24, "R5 gate high");
        // R12: unit 1 activity leaves unit 0 untouched
        check("R12 unit0 flag", 16'(ovf_flag[0]), 16'(m_flag[0]));

        // random traffic, R12 overall
        for (int k = 0; k < 6000; k++) begin
            int r = $urandom_range(0, 15);
            if ($urandom_range(0, 2) == 0) cnt_pin = 2'($urandom);
            if ($urandom_range(0, 7) == 0) gate_pin = 2'($urandom);
            if (r < 2) begin
                bus_addr = 3'($urandom_range(0, 3)); bus_wdata = 8'($urandom); bus_wr = 1'b1;
            end else if (r == 2) begin
                bus_addr = 3'd4; bus_wdata = 8'($urandom) & 8'h77; bus_wr = 1'b1;
            end else if (r == 3) begin
                bus_addr = 3'd5; bus_wdata = (8'($urandom) & 8'h8C) | 8'h03; bus_wr = 1'b1;
            end
            cyc("R12 random");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule